// File: doc/BRIEF.md
# Dual-Processor Gate Lock Notification Tracker

This block watches a bank of hardware gates that two processors share. When one processor tries to take a gate that the other already holds, the attempt fails. The block remembers which processor lost and waits for the gate to be released. Once the gate is free, it raises a notification for the losing processor, so that processor can retry instead of polling.

Each gate has its own small state machine with five states. A pending notification ends when the notified processor takes the gate. If the other processor takes the gate first, the notification is withdrawn and the machine goes back to waiting for the next release. Each processor sees a bitmap with one bit per gate in the notify state, plus an interrupt line that is the OR of its bitmap. A simple read port returns either bitmap at its fixed offset. A per-gate clear strobe, driven by the secure gate reset logic, forces a gate's tracker back to idle.

Top module: `sema_ntf_top`

## Requirements
- R1: After synchronous reset, both bitmaps are all zeros, both interrupt lines are low and `rd_data` is zero.
- R2: A failed attempt moves an idle gate to a waiting state on the next clock edge. A failed attempt is a `try_pX` strobe while the gate's owner field holds the other processor (owner codes: 2'b01 = processor 0, 2'b10 = processor 1, any other value = free). The gate's bitmap bits stay 0 while it waits.
- R3: A waiting gate whose owner field reads free moves to notify for the processor that failed. Bit n of that processor's bitmap is 1 after that edge.
- R4: A gate notifying processor X, whose owner field then reads X, returns to idle and its bitmap bit clears after that edge.
- R5: A gate notifying processor X, whose owner field then reads the other processor, clears its bitmap bit and waits again. It notifies X again on the next free cycle.
- R6: Attempts that are not failures do not change an idle gate: an attempt on a free gate, or by the current owner. A repeated failed attempt by the same processor while its gate waits leaves the gate waiting for that processor.
- R7: A 1 on `gate_clr[n]` returns gate n to idle on the next edge. It takes priority over every other input of that gate.
- R8: `irq_p0` is 1 exactly when `ntf_p0` is non-zero, and `irq_p1` is 1 exactly when `ntf_p1` is non-zero.
- R9: With `rd_en` high at an edge, `rd_data` after that edge holds the processor 0 bitmap (address 0x80) or the processor 1 bitmap (address 0x88), as it stood before the edge. Any other address, or `rd_en` low, gives zero.
- R10: No gate ever shows a 1 in both bitmaps at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_owner | input | 2*NUM_GATES | Per-gate owner field, gate n at bits [2n+1:2n] |
| try_p0 | input | NUM_GATES | Processor 0 lock-attempt strobes, one per gate |
| try_p1 | input | NUM_GATES | Processor 1 lock-attempt strobes, one per gate |
| gate_clr | input | NUM_GATES | Secure-reset strobes forcing a gate's tracker idle |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | NUM_GATES | Registered read data |
| ntf_p0 | output | NUM_GATES | Processor 0 notification bitmap |
| ntf_p1 | output | NUM_GATES | Processor 1 notification bitmap |
| irq_p0 | output | 1 | Processor 0 interrupt |
| irq_p1 | output | 1 | Processor 1 interrupt |

## Verification
The hardest case to reach is the withdrawal path. A gate must fail, be released, start notifying, and then be grabbed by the processor that already held it, before the notified processor acts. Uniform random owners rarely walk that chain on a given gate. The stimulus therefore drives the chain, and a repeated failed attempt during the wait, as directed sequences on single gates. A random phase then holds each gate's owner for several cycles at a time and favours the free value, so release-then-regrab sequences happen often across all gates.

// File: rtl/sema_ntf_pkg.sv
package sema_ntf_pkg;

  // Bit 2 marks a notify state, bit 1 a waiting state, bit 0 the failed processor.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_WAIT0 = 3'b010,
    ST_WAIT1 = 3'b011,
    ST_NTF0  = 3'b100,
    ST_NTF1  = 3'b101
  } ntf_state_e;

  localparam logic [1:0] OWN_P0 = 2'b01;
  localparam logic [1:0] OWN_P1 = 2'b10;

endpackage

// File: rtl/sema_ntf_gate.sv
module sema_ntf_gate
  import sema_ntf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] owner,
  input  logic       try_p0,
  input  logic       try_p1,
  input  logic       clr,
  output logic       ntf0,
  output logic       ntf1
);

  ntf_state_e state_q, state_d;
  logic own0, own1, is_free, fail0, fail1;

  assign own0    = (owner == OWN_P0);
  assign own1    = (owner == OWN_P1);
  assign is_free = !own0 && !own1;
  assign fail0   = try_p0 && own1;
  assign fail1   = try_p1 && own0;

  always_comb begin
    state_d = state_q;
    if (clr) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fail0)      state_d = ST_WAIT0;
          else if (fail1) state_d = ST_WAIT1;
        end
        ST_WAIT0: if (is_free) state_d = ST_NTF0;
        ST_WAIT1: if (is_free) state_d = ST_NTF1;
        ST_NTF0: begin
          if (own0)      state_d = ST_IDLE;
          else if (own1) state_d = ST_WAIT0;
        end
        ST_NTF1: begin
          if (own1)      state_d = ST_IDLE;
          else if (own0) state_d = ST_WAIT1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign ntf0 = (state_q == ST_NTF0);
  assign ntf1 = (state_q == ST_NTF1);

  assert_idle_fail_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !clr && (fail0 || fail1)) |=> (state_q == ST_WAIT0 || state_q == ST_WAIT1));

  assert_wait_release_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT0 && !clr && is_free) |=> ntf0);

  assert_owner_take_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NTF1 && !clr && own1) |=> (state_q == ST_IDLE));

  assert_regrab_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NTF0 && !clr && own1) |=> (state_q == ST_WAIT0 && !ntf0));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sema_ntf_readout.sv
module sema_ntf_readout #(
  parameter int                NUM_GATES = 16,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] P0_OFS    = 8'h80,
  parameter logic [ADDR_W-1:0] P1_OFS    = 8'h88
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NUM_GATES-1:0] map_p0,
  input  logic [NUM_GATES-1:0] map_p1,
  output logic [NUM_GATES-1:0] rd_data,
  output logic                 irq_p0,
  output logic                 irq_p1
);

  logic [NUM_GATES-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_en) begin
      if (rd_addr == P0_OFS)      sel = map_p0;
      else if (rd_addr == P1_OFS) sel = map_p1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end

  assign irq_p0 = |map_p0;
  assign irq_p1 = |map_p1;

  assert_read_p1_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == P1_OFS) |=> (rd_data == $past(map_p1)));

  assert_read_other_R9: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> (rd_data == '0));

endmodule

// File: rtl/sema_ntf_top.sv
module sema_ntf_top #(
  parameter int                NUM_GATES = 16,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] P0_OFS    = 8'h80,
  parameter logic [ADDR_W-1:0] P1_OFS    = 8'h88
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_GATES-1:0] gate_owner,
  input  logic [NUM_GATES-1:0]   try_p0,
  input  logic [NUM_GATES-1:0]   try_p1,
  input  logic [NUM_GATES-1:0]   gate_clr,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [NUM_GATES-1:0]   rd_data,
  output logic [NUM_GATES-1:0]   ntf_p0,
  output logic [NUM_GATES-1:0]   ntf_p1,
  output logic                   irq_p0,
  output logic                   irq_p1
);

  localparam int OWN_W = 2;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    sema_ntf_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .owner  (gate_owner[g*OWN_W +: OWN_W]),
      .try_p0 (try_p0[g]),
      .try_p1 (try_p1[g]),
      .clr    (gate_clr[g]),
      .ntf0   (ntf_p0[g]),
      .ntf1   (ntf_p1[g])
    );
  end

  sema_ntf_readout #(
    .NUM_GATES (NUM_GATES),
    .ADDR_W    (ADDR_W),
    .P0_OFS    (P0_OFS),
    .P1_OFS    (P1_OFS)
  ) u_readout (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .map_p0  (ntf_p0),
    .map_p1  (ntf_p1),
    .rd_data (rd_data),
    .irq_p0  (irq_p0),
    .irq_p1  (irq_p1)
  );

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    ((ntf_p0 & ntf_p1) == '0));

  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (ntf_p0 == '0 && ntf_p1 == '0 && rd_data == '0));

endmodule

// File: tb/sema_ntf_top_tb_top.sv
module sema_ntf_top_tb_top;

  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [2*N-1:0] gate_owner = '0;
  logic [N-1:0]   try_p0 = '0, try_p1 = '0, gate_clr = '0;
  logic           rd_en = 1'b0;
  logic [7:0]     rd_addr = '0;
  logic [N-1:0]   rd_data, ntf_p0, ntf_p1;
  logic           irq_p0, irq_p1;

  always #10 clk = ~clk;

  sema_ntf_top dut_i (
    .clk(clk), .rst(rst), .gate_owner(gate_owner), .try_p0(try_p0), .try_p1(try_p1),
    .gate_clr(gate_clr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ntf_p0(ntf_p0), .ntf_p1(ntf_p1), .irq_p0(irq_p0), .irq_p1(irq_p1)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  // model states: 0 idle, 1 wait p0, 2 wait p1, 3 notify p0, 4 notify p1
  int m_st [N];
  logic [N-1:0] exp_rd = '0;

  function automatic int nxt(int s, logic [1:0] own, logic t0, logic t1, logic c);
    bit o0 = (own == 2'b01);
    bit o1 = (own == 2'b10);
    bit fr = !o0 && !o1;
    if (c) return 0;
    case (s)
      0: if (t0 && o1) return 1; else if (t1 && o0) return 2; else return 0;
      1: return fr ? 3 : 1;
      2: return fr ? 4 : 2;
      3: return o0 ? 0 : (o1 ? 1 : 3);
      4: return o1 ? 0 : (o0 ? 2 : 4);
      default: return 0;
    endcase
  endfunction

  function automatic logic [N-1:0] map_of(int code);
    logic [N-1:0] m = '0;
    for (int g = 0; g < N; g++) m[g] = (m_st[g] == code);
    return m;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare current outputs, then drive one cycle of inputs and advance the model
  task automatic step(string tag, logic [2*N-1:0] own, logic [N-1:0] t0, logic [N-1:0] t1,
                      logic [N-1:0] c, logic re, logic [7:0] ad);
    logic [N-1:0] e0, e1;
    @(negedge clk);
    e0 = map_of(3); e1 = map_of(4);
    check(tag, ntf_p0, e0);
    check(tag, ntf_p1, e1);
    check("R10", ntf_p0 & ntf_p1, '0);
    check("R8", {15'd0, irq_p0}, {15'd0, |e0});
    check("R8", {15'd0, irq_p1}, {15'd0, |e1});
    check("R9", rd_data, exp_rd);
    gate_owner = own; try_p0 = t0; try_p1 = t1; gate_clr = c; rd_en = re; rd_addr = ad;
    exp_rd = !re ? '0 : (ad == 8'h80) ? e0 : (ad == 8'h88) ? e1 : '0;
    for (int g = 0; g < N; g++) m_st[g] = nxt(m_st[g], own[2*g +: 2], t0[g], t1[g], c[g]);
  endtask

  function automatic logic [2*N-1:0] own1(int g, logic [1:0] v);
    logic [2*N-1:0] o = '0;
    o[2*g +: 2] = v;
    return o;
  endfunction

  initial begin
    for (int g = 0; g < N; g++) m_st[g] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    step("R1", '0, '0, '0, '0, 1'b1, 8'h80);
    // R6: attempts on a free gate or by the owner are not failures
    step("R6", '0, 16'hFFFF, 16'hFFFF, '0, 1'b0, 8'h00);
    step("R6", {N{2'b01}}, 16'hFFFF, '0, '0, 1'b0, 8'h00);
    step("R6", '0, '0, '0, '0, 1'b0, 8'h00);
    // gate 3: p1 holds, p0 fails (R2), fails again (R6)
    step("R2", own1(3, 2'b10), 16'h0008, '0, '0, 1'b0, 8'h00);
    step("R2", own1(3, 2'b10), 16'h0008, '0, '0, 1'b0, 8'h00);
    step("R6", own1(3, 2'b10), '0, '0, '0, 1'b1, 8'h80);
    // release -> notify p0 (R3)
    step("R3", own1(3, 2'b00), '0, '0, '0, 1'b1, 8'h80);
    step("R3", own1(3, 2'b00), '0, '0, '0, 1'b1, 8'h80);
    // p1 regrabs -> withdrawn, waiting again (R5)
    step("R5", own1(3, 2'b10), '0, '0, '0, 1'b1, 8'h80);
    step("R5", own1(3, 2'b00), '0, '0, '0, 1'b1, 8'h88);
    step("R5", own1(3, 2'b01), '0, '0, '0, 1'b1, 8'h80);
    // p0 took it -> idle (R4); stays idle when freed
    step("R4", own1(3, 2'b00), '0, '0, '0, 1'b1, 8'h80);
    step("R4", '0, '0, '0, '0, 1'b1, 8'h44);
    // gate 5: p1 fails while p0 holds, notify, then secure clear (R7)
    step("R2", own1(5, 2'b01), '0, 16'h0020, '0, 1'b0, 8'h00);
    step("R3", own1(5, 2'b00), '0, '0, '0, 1'b1, 8'h88);
    step("R7", own1(5, 2'b10), '0, '0, 16'h0020, 1'b1, 8'h88);
    step("R7", '0, '0, '0, '0, 1'b1, 8'h88);
    // clear beats a failed attempt (R7)
    step("R7", own1(7, 2'b01), '0, 16'h0080, 16'h0080, 1'b0, 8'h00);
    step("R7", '0, '0, '0, '0, 1'b0, 8'h00);
    // random phase
    begin
      logic [2*N-1:0] own = '0;
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 4000; i++) begin
        logic [N-1:0] t0, t1, c;
        logic [7:0] ad;
        for (int g = 0; g < N; g++)
          if ($urandom_range(0, 3) == 0) begin
            int r = $urandom_range(0, 9);
            own[2*g +: 2] = (r < 5) ? 2'b00 : (r < 7) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
          end
        t0 = N'($urandom) & N'($urandom);
        t1 = N'($urandom) & N'($urandom);
        c  = ($urandom_range(0, 15) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
        case ($urandom_range(0, 3))
          0: ad = 8'h80;
          1: ad = 8'h88;
          default: ad = 8'($urandom);
        endcase
        step("R2/R3/R4/R5 random", own, t0, t1, c, $urandom_range(0, 1) == 1, ad);
      end
    end
    step("R9 final", '0, '0, '0, '0, 1'b0, 8'h00);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule